// File: doc/BRIEF.md
# DTMF Tone Steering and Code Latch

This block sits after a dual-tone classifier. The classifier supplies a tone-present flag and a 4-bit digit code. The block decides whether that tone is a real keypress. It replaces an analog resistor-capacitor guard-time network with counters that advance on a millisecond tick input.

A first stage raises an early-steering flag once a tone with a stable code has been seen for a fixed detect delay. It drops the flag after a fixed release delay of absence. A second stage times how long early steering stays high, using a programmable acquisition guard. If the tone lasts long enough, that stage latches the code onto the output bus and raises data-valid a short setup time later. When the tone stops, a programmable release guard decides whether the silence is a real inter-digit pause or a short dropout to bridge.

The tristate data bus is modelled as a value and a drive-enable pair. Power-down holds the block idle. After reset, and after power-down is released, nothing is detected until a power-up delay has passed.

Top module: `dtmf_steer_latch`

## Requirements
- R1: `earlySteer` rises once `tonePresent` has stayed high with an unchanged `toneCode` for DET_TICKS (default 8) ticks. It falls after REL_TICKS (default 4) ticks of continuous absence. A code that differs from the steered one counts as absence.
- R2: A tone is accepted only if `earlySteer` stays high for `acqGuard` ticks. With defaults (acqGuard 22, DET_TICKS 8) a tone shorter than 20 ticks is rejected and one of 42 ticks or more is accepted. A rejected tone leaves `dataValid` low and the bus unchanged.
- R3: `acqGuard` and `relGuard` are read directly as tick counts. Lowering `acqGuard` to 2 makes an 18-tick tone acceptable. Lowering `relGuard` to 2 makes a 10-tick gap end the digit.
- R4: On acceptance the code is latched onto the bus first. `dataValid` rises SETUP_TICKS (default 4) ticks later, and is low in the cycle the new code first appears.
- R5: Once steering falls, `dataValid` drops after `relGuard` more ticks of absence. With defaults (relGuard 26), a gap shorter than 20 ticks followed by the same code keeps `dataValid` high, and a pause of 42 ticks or more ends the digit.
- R6: After the digit ends, `dataValid` is low and the bus keeps the last accepted code until a new code is latched.
- R7: If the code changes while a digit is held, the change is handled as a release followed by a new acquisition. `dataValid` goes low while the bus still shows the old code. The new code is then latched, and `dataValid` rises again.
- R8: While `outEnable` is low, `busDriveEn` is 0 and `busData` reads 0. While it is high, `busDriveEn` is 1 and `busData` shows the latched code. Toggling `outEnable` does not alter the latched code.
- R9: One cycle after `powerDown` goes high, `dataValid` and `earlySteer` are low and the latched code is cleared to 0.
- R10: After reset, and after `powerDown` falls, no tone is detected for PU_TICKS (default 30) ticks. After that, detection resumes.
- R11: In reset, `dataValid` and `earlySteer` are 0 and `busData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle pulse per millisecond |
| tonePresent | input | 1 | Classifier reports a valid tone pair |
| toneCode | input | 4 | Classifier digit code |
| powerDown | input | 1 | Holds the block idle while high |
| outEnable | input | 1 | Drive enable for the data bus |
| acqGuard | input | 6 | Acquisition guard time in ticks |
| relGuard | input | 6 | Release guard time in ticks |
| earlySteer | output | 1 | Early-steering flag |
| busData | output | 4 | Data bus value (0 when not driven) |
| busDriveEn | output | 1 | Data bus drive enable |
| dataValid | output | 1 | Accepted digit present |

## Verification
A wrong control state shows at the ports within one guard window, a few tens of ticks. A missed transition leaves `dataValid` high after a long pause, or low at the end of a long tone. A wrong latch strobe shows as a bus code that differs from the last accepted digit, and this is visible on the very next sample. An off-by-several tick count moves the accept and bridge boundaries. The bench therefore uses tones and gaps just inside each boundary, and also measures the spacing between the latch and `dataValid`.

// File: rtl/steer_pkg.sv
package steer_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_ACQ,
    ST_SETUP,
    ST_VALID,
    ST_REL
  } steerState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic cntClear;
    logic latchCode;
    logic clearCode;
  } dpStrobe_t;

endpackage

// File: rtl/tone_steer_detect.sv
module tone_steer_detect #(
  parameter int CODE_W    = 4,
  parameter int DET_TICKS = 8,
  parameter int REL_TICKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hold,
  input  logic              msTick,
  input  logic              tonePresent,
  input  logic [CODE_W-1:0] toneCode,
  output logic              est,
  output logic [CODE_W-1:0] estCode
);

  localparam int DW = $clog2(DET_TICKS + 1);
  localparam int RW = $clog2(REL_TICKS + 1);
  localparam logic [DW-1:0] DET_LAST = DW'(DET_TICKS - 1);
  localparam logic [RW-1:0] REL_LAST = RW'(REL_TICKS - 1);

  logic [DW-1:0]     presCnt;
  logic [RW-1:0]     absCnt;
  logic [CODE_W-1:0] candCode;
  logic              sameEst;

  assign sameEst = tonePresent && (toneCode == estCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      est      <= 1'b0;
      estCode  <= '0;
      candCode <= '0;
      presCnt  <= '0;
      absCnt   <= '0;
    end else if (hold) begin
      est      <= 1'b0;
      candCode <= '0;
      presCnt  <= '0;
      absCnt   <= '0;
    end else if (!est) begin
      absCnt <= '0;
      if (!tonePresent) begin
        presCnt <= '0;
      end else if (toneCode != candCode) begin
        candCode <= toneCode;
        presCnt  <= '0;
      end else if (msTick) begin
        if (presCnt == DET_LAST) begin
          est     <= 1'b1;
          estCode <= candCode;
          presCnt <= '0;
        end else begin
          presCnt <= presCnt + 1'b1;
        end
      end
    end else begin
      if (sameEst) begin
        absCnt <= '0;
      end else if (msTick) begin
        if (absCnt == REL_LAST) begin
          est    <= 1'b0;
          absCnt <= '0;
        end else begin
          absCnt <= absCnt + 1'b1;
        end
      end
    end
  end

  // R1: steering only rises out of a cycle with a tone present
  assert_est_rise_tone_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(est) |-> $past(tonePresent));

endmodule

// File: rtl/steer_datapath.sv
module steer_datapath
  import steer_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msTick,
  input  dpStrobe_t         strb,
  input  logic [CODE_W-1:0] estCode,
  input  logic              outEnable,
  input  logic              dataValid,
  output logic [CNT_W-1:0]  cnt,
  output logic [CODE_W-1:0] latchedCode,
  output logic [CODE_W-1:0] busData,
  output logic              busDriveEn
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.cntClear) begin
      cnt <= '0;
    end else if (msTick && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchedCode <= '0;
    end else if (strb.clearCode) begin
      latchedCode <= '0;
    end else if (strb.latchCode) begin
      latchedCode <= estCode;
    end
  end

  assign busDriveEn = outEnable;
  assign busData    = outEnable ? latchedCode : '0;

  // R4: bus settled when data-valid rises
  assert_bus_stable_at_dv_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> $stable(latchedCode));

  // R7: the latch never changes under a high data-valid
  assert_latch_while_dv_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (latchedCode != $past(latchedCode)) |-> !dataValid);

endmodule

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import steer_pkg::*;
#(
  parameter int CODE_W      = 4,
  parameter int CNT_W       = 8,
  parameter int GUARD_W     = 6,
  parameter int SETUP_TICKS = 4,
  parameter int PU_TICKS    = 30
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               powerDown,
  input  logic               est,
  input  logic [CODE_W-1:0]  estCode,
  input  logic [CODE_W-1:0]  latchedCode,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [GUARD_W-1:0] acqGuard,
  input  logic [GUARD_W-1:0] relGuard,
  output dpStrobe_t          strb,
  output logic               dataValid,
  output logic               holdDet
);

  localparam logic [CNT_W-1:0] PU_LIM    = CNT_W'(PU_TICKS);
  localparam logic [CNT_W-1:0] SETUP_LIM = CNT_W'(SETUP_TICKS);

  steerState_t      state, stateNxt;
  logic             dvNxt;
  logic [CNT_W-1:0] acqLim, relLim;

  assign acqLim  = CNT_W'(acqGuard);
  assign relLim  = CNT_W'(relGuard);
  assign holdDet = powerDown || (state == ST_PWRUP);

  always_comb begin
    stateNxt = state;
    dvNxt    = dataValid;
    strb     = '0;
    if (powerDown) begin
      stateNxt       = ST_PWRUP;
      dvNxt          = 1'b0;
      strb.cntClear  = 1'b1;
      strb.clearCode = 1'b1;
    end else begin
      unique case (state)
        ST_PWRUP: begin
          dvNxt = 1'b0;
          if (cnt >= PU_LIM) begin
            stateNxt      = ST_IDLE;
            strb.cntClear = 1'b1;
          end
        end
        ST_IDLE: begin
          dvNxt = 1'b0;
          if (est) begin
            stateNxt      = ST_ACQ;
            strb.cntClear = 1'b1;
          end
        end
        ST_ACQ: begin
          if (!est) begin
            stateNxt = ST_IDLE;
          end else if (cnt >= acqLim) begin
            stateNxt       = ST_SETUP;
            strb.latchCode = 1'b1;
            strb.cntClear  = 1'b1;
          end
        end
        ST_SETUP: begin
          if (cnt >= SETUP_LIM) begin
            stateNxt = ST_VALID;
            dvNxt    = 1'b1;
          end
        end
        ST_VALID: begin
          if (!est) begin
            stateNxt      = ST_REL;
            strb.cntClear = 1'b1;
          end
        end
        ST_REL: begin
          if (est) begin
            strb.cntClear = 1'b1;
            if (estCode == latchedCode) begin
              stateNxt = ST_VALID;
            end else begin
              stateNxt = ST_ACQ;
              dvNxt    = 1'b0;
            end
          end else if (cnt >= relLim) begin
            stateNxt = ST_IDLE;
            dvNxt    = 1'b0;
          end
        end
        default: begin
          stateNxt = ST_PWRUP;
          dvNxt    = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_PWRUP;
      dataValid <= 1'b0;
    end else begin
      state     <= stateNxt;
      dataValid <= dvNxt;
    end
  end

  // R9: power-down empties the outputs on the next edge
  assert_pd_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> (!dataValid && !est));

  // R2: a digit is flagged only after steering was up
  assert_dv_needs_steer_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> $past(est));

  // R10: nothing is flagged during the power-up wait
  assert_no_dv_in_pwrup_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PWRUP) |-> !dataValid);

endmodule

// File: rtl/dtmf_steer_latch.sv
module dtmf_steer_latch
  import steer_pkg::*;
#(
  parameter int CODE_W      = 4,
  parameter int GUARD_W     = 6,
  parameter int CNT_W       = 8,
  parameter int DET_TICKS   = 8,
  parameter int REL_TICKS   = 4,
  parameter int SETUP_TICKS = 4,
  parameter int PU_TICKS    = 30
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               msTick,
  input  logic               tonePresent,
  input  logic [CODE_W-1:0]  toneCode,
  input  logic               powerDown,
  input  logic               outEnable,
  input  logic [GUARD_W-1:0] acqGuard,
  input  logic [GUARD_W-1:0] relGuard,
  output logic               earlySteer,
  output logic [CODE_W-1:0]  busData,
  output logic               busDriveEn,
  output logic               dataValid
);

  dpStrobe_t         strb;
  logic              est;
  logic              holdDet;
  logic [CODE_W-1:0] estCode;
  logic [CODE_W-1:0] latchedCode;
  logic [CNT_W-1:0]  cnt;

  tone_steer_detect #(
    .CODE_W(CODE_W), .DET_TICKS(DET_TICKS), .REL_TICKS(REL_TICKS)
  ) u_detect (
    .clk(clk), .rstN(rstN), .hold(holdDet), .msTick(msTick),
    .tonePresent(tonePresent), .toneCode(toneCode),
    .est(est), .estCode(estCode)
  );

  steer_ctrl #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .GUARD_W(GUARD_W),
    .SETUP_TICKS(SETUP_TICKS), .PU_TICKS(PU_TICKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .powerDown(powerDown), .est(est),
    .estCode(estCode), .latchedCode(latchedCode), .cnt(cnt),
    .acqGuard(acqGuard), .relGuard(relGuard),
    .strb(strb), .dataValid(dataValid), .holdDet(holdDet)
  );

  steer_datapath #(
    .CODE_W(CODE_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .msTick(msTick), .strb(strb),
    .estCode(estCode), .outEnable(outEnable), .dataValid(dataValid),
    .cnt(cnt), .latchedCode(latchedCode),
    .busData(busData), .busDriveEn(busDriveEn)
  );

  assign earlySteer = est;

endmodule

// File: tb/dtmf_steer_latch_tb.sv
module dtmf_steer_latch_tb;

  localparam int TICK_CLKS = 4;

  typedef struct packed {
    logic [3:0]  code;
    logic [7:0]  onT;
    logic        acc;
  } vec_t;

  localparam int VEC_N = 8;
  localparam vec_t VEC [VEC_N] = '{
    '{code: 4'd3,  onT: 8'd10, acc: 1'b0},
    '{code: 4'd7,  onT: 8'd45, acc: 1'b1},
    '{code: 4'd9,  onT: 8'd19, acc: 1'b0},
    '{code: 4'd12, onT: 8'd42, acc: 1'b1},
    '{code: 4'd1,  onT: 8'd15, acc: 1'b0},
    '{code: 4'd0,  onT: 8'd60, acc: 1'b1},
    '{code: 4'd10, onT: 8'd5,  acc: 1'b0},
    '{code: 4'd15, onT: 8'd50, acc: 1'b1}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       msTick = 1'b0;
  logic       tonePresent = 1'b0;
  logic [3:0] toneCode = '0;
  logic       powerDown = 1'b0;
  logic       outEnable = 1'b1;
  logic [5:0] acqGuard = 6'd22;
  logic [5:0] relGuard = 6'd26;
  logic       earlySteer, busDriveEn, dataValid;
  logic [3:0] busData;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  int tickDiv = 0;
  logic [3:0] expLatched = '0;

  dtmf_steer_latch u_dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .tonePresent(tonePresent),
    .toneCode(toneCode), .powerDown(powerDown), .outEnable(outEnable),
    .acqGuard(acqGuard), .relGuard(relGuard), .earlySteer(earlySteer),
    .busData(busData), .busDriveEn(busDriveEn), .dataValid(dataValid)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    cycles  <= cycles + 1;
    tickDiv <= (tickDiv == TICK_CLKS - 1) ? 0 : tickDiv + 1;
    msTick  <= (tickDiv == TICK_CLKS - 1);
    if (cycles > 150000) begin
      nChecks = nChecks + 1;
      nFail   = nFail + 1;
      $display("FAIL watchdog: got %0d cycles expected end before 150000", cycles);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic waitTicks(input int n);
    repeat (n * TICK_CLKS) @(negedge clk);
  endtask

  // wait n ticks, count samples with data-valid low, remember bus at first low
  task automatic watchDv(input int n, output int lowSeen, output int busAtLow);
    lowSeen  = 0;
    busAtLow = -1;
    repeat (n * TICK_CLKS) begin
      @(negedge clk);
      if (!dataValid) begin
        if (lowSeen == 0) busAtLow = int'(busData);
        lowSeen++;
      end
    end
  endtask

  task automatic tone(input logic [3:0] c, input bit on);
    @(negedge clk);
    toneCode    = c;
    tonePresent = on;
  endtask

  initial begin
    int lowSeen, busAtLow, tLatch, tDv, dvAtLatch;

    // R11: reset state
    tonePresent = 1'b1;
    toneCode    = 4'd5;
    repeat (5) @(negedge clk);
    check("R11 dataValid in reset", int'(dataValid), 0);
    check("R11 earlySteer in reset", int'(earlySteer), 0);
    check("R11 busData in reset", int'(busData), 0);
    rstN = 1'b1;

    // R10: power-up wait after reset ignores a present tone
    waitTicks(20);
    check("R10 no steering during power-up", int'(earlySteer), 0);
    tone(4'd5, 1'b0);
    waitTicks(25);

    // vector table: R2 acceptance, R5 long pause ends digit, R6 hold
    for (int i = 0; i < VEC_N; i++) begin
      tone(VEC[i].code, 1'b1);
      waitTicks(int'(VEC[i].onT));
      if (VEC[i].acc) expLatched = VEC[i].code;
      check($sformatf("R2 vec%0d dataValid at tone end", i), int'(dataValid), int'(VEC[i].acc));
      check($sformatf("R2 vec%0d bus at tone end", i), int'(busData), int'(expLatched));
      tone(VEC[i].code, 1'b0);
      waitTicks(45);
      check($sformatf("R5 vec%0d dataValid after 45-tick pause", i), int'(dataValid), 0);
      check($sformatf("R6 vec%0d bus holds last code", i), int'(busData), int'(expLatched));
    end

    // R1: early steering timing
    tone(4'd6, 1'b1);
    waitTicks(4);
    check("R1 earlySteer low before detect delay", int'(earlySteer), 0);
    waitTicks(10);
    check("R1 earlySteer high after detect delay", int'(earlySteer), 1);
    waitTicks(36);
    tone(4'd6, 1'b0);
    waitTicks(2);
    check("R1 earlySteer held inside release delay", int'(earlySteer), 1);
    waitTicks(8);
    check("R1 earlySteer low after release delay", int'(earlySteer), 0);
    waitTicks(40);

    // R4: latch precedes data-valid by the setup time
    tone(4'd2, 1'b1);
    tLatch = -1; tDv = -1; dvAtLatch = -1;
    for (int k = 0; k < 60 * TICK_CLKS; k++) begin
      @(negedge clk);
      if (tLatch < 0 && busData == 4'd2) begin
        tLatch    = k;
        dvAtLatch = int'(dataValid);
      end
      if (tDv < 0 && dataValid) tDv = k;
    end
    check("R4 dataValid low when code appears", dvAtLatch, 0);
    check("R4 setup spacing in range", int'((tDv - tLatch) >= 3 * TICK_CLKS &&
                                           (tDv - tLatch) <= 5 * TICK_CLKS), 1);
    tone(4'd2, 1'b0);
    waitTicks(45);

    // R5: short gap bridged
    tone(4'd8, 1'b1);
    waitTicks(45);
    tone(4'd8, 1'b0);
    watchDv(10, lowSeen, busAtLow);
    tone(4'd8, 1'b1);
    waitTicks(20);
    check("R5 10-tick gap keeps dataValid", lowSeen, 0);
    check("R5 dataValid after bridged gap", int'(dataValid), 1);
    tone(4'd8, 1'b0);
    waitTicks(45);

    // R3: programmable guards
    acqGuard = 6'd2;
    relGuard = 6'd2;
    tone(4'd11, 1'b1);
    waitTicks(18);
    check("R3 short guard accepts 18-tick tone", int'(dataValid), 1);
    check("R3 short guard latches code", int'(busData), 11);
    tone(4'd11, 1'b0);
    watchDv(10, lowSeen, busAtLow);
    check("R3 short release guard ends digit in gap", int'(lowSeen > 0), 1);
    waitTicks(35);
    acqGuard = 6'd22;
    relGuard = 6'd26;
    waitTicks(5);

    // R7: code change mid-digit
    tone(4'd4, 1'b1);
    waitTicks(45);
    tone(4'd13, 1'b1);
    watchDv(60, lowSeen, busAtLow);
    check("R7 dataValid dropped on code change", int'(lowSeen > 0), 1);
    check("R7 old code shown when dataValid fell", busAtLow, 4);
    check("R7 new code latched", int'(busData), 13);
    check("R7 dataValid back for new code", int'(dataValid), 1);

    // R8: output enable
    @(negedge clk); outEnable = 1'b0;
    @(negedge clk);
    check("R8 drive off", int'(busDriveEn), 0);
    check("R8 bus reads 0 undriven", int'(busData), 0);
    outEnable = 1'b1;
    @(negedge clk);
    check("R8 drive on", int'(busDriveEn), 1);
    check("R8 code kept across enable toggle", int'(busData), 13);

    // R9: power-down
    powerDown = 1'b1;
    @(negedge clk);
    check("R9 dataValid low in power-down", int'(dataValid), 0);
    check("R9 earlySteer low in power-down", int'(earlySteer), 0);
    check("R9 latched code cleared", int'(busData), 0);
    waitTicks(5);
    powerDown = 1'b0;

    // R10: wait after power-down release, tone still present
    waitTicks(20);
    check("R10 no steering after release", int'(earlySteer), 0);
    waitTicks(25);
    check("R10 detection resumes", int'(earlySteer), 1);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule